// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block hands out a shared packet memory, divided into fixed 256-byte pages, to transmit and receive traffic. The memory is handed out by packet number rather than as a plain queue. A host issues commands on a small command port: allocate a run of pages for a packet it is about to write, queue an allocated packet for transmission, release the oldest received packet, or reset the whole allocator. A packet number is the index of the first page of its run. A per-page size table remembers how many pages each packet holds, so that it can later be freed from its number alone.

Allocation and release are multi-cycle operations, and a busy flag is high while either is in progress. An allocation ends by updating a result register, made of the packet number and a failure flag, and by setting a done interrupt bit. The host clears that bit by pulsing a write-one-to-clear input. Received frames are signalled by a strobe carrying the frame's page code. The block allocates their pages itself and files the packet number in a receive FIFO, which shows its head and an empty flag.

The transmit queue is presented to the MAC as a valid/ready stream. `tx_valid` with `tx_pkt` names the head packet. The MAC acknowledges with `tx_done`, which acts as ready. The head is held stable until it is acknowledged, and a `tx_done` while `tx_valid` is low has no effect. Sent packets are always released automatically, and a transmit-empty interrupt bit is raised when the queue drains.

Top module: `pkt_page_alloc`

## Requirements
- R1: After rst_n is deasserted: busy=0, alloc_fail=0, alloc_pkt=0, irq_alloc=0, irq_txempty=0, rx_empty=1, tx_valid=0, and all 32 pages are free.
- R2: An allocate command (cmd_op=0) with page code n (0..7) asks for n+1 contiguous pages. busy is high for the 2 cycles after the command is accepted. At the end of those cycles, alloc_pkt becomes the lowest start page of a free run that fits, alloc_fail=0, and irq_alloc=1.
- R3: An allocate command with a page code of 8 or more (more than 8 pages) is rejected. It completes with alloc_fail=1 and irq_alloc=1, leaves alloc_pkt unchanged and consumes no pages.
- R4: An allocate command for which no free run fits completes with alloc_fail=1 and irq_alloc=1, with alloc_pkt unchanged. A later successful allocation clears alloc_fail.
- R5: A pulse on irq_alloc_clr clears irq_alloc. If an allocation completes in the same cycle, the set wins.
- R6: An enqueue command (cmd_op=1) appends cmd_pkt to the transmit queue. The queue is presented in order on tx_valid/tx_pkt, and its head is held until tx_done.
- R7: tx_done while tx_valid=1 frees the head packet's pages and pops it. Popping the last entry sets irq_txempty, and irq_txempty_clr clears it.
- R8: rx_frame with page code n allocates n+1 pages first-fit and pushes the start page onto the receive FIFO, which clears rx_empty and shows the oldest entry on rx_head. If no run fits, the frame is dropped.
- R9: A release command (cmd_op=2) holds busy high for 4 cycles. It then frees the pages of the rx_head packet and pops it. On an empty FIFO it frees nothing.
- R10: A command presented while busy=1 is ignored.
- R11: A reset command (cmd_op=3) frees every page, empties both queues and clears alloc_fail at the next edge, without raising busy.
- R12: When a received frame and a host allocation complete in the same cycle, the frame is served first, and the host's search sees only the pages that remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command strobe, accepted when busy=0 |
| cmd_op | input | 2 | 0 allocate, 1 enqueue, 2 release, 3 reset |
| cmd_arg | input | 4 | Page code for allocate (pages minus one) |
| cmd_pkt | input | 5 | Packet number for enqueue |
| busy | output | 1 | Allocate or release in progress |
| alloc_pkt | output | 5 | Last granted packet number |
| alloc_fail | output | 1 | Last allocation failed |
| irq_alloc | output | 1 | Allocation-done status bit |
| irq_alloc_clr | input | 1 | Write-one-to-clear for irq_alloc |
| irq_txempty | output | 1 | Transmit-queue-drained status bit |
| irq_txempty_clr | input | 1 | Write-one-to-clear for irq_txempty |
| rx_frame | input | 1 | Frame-received strobe |
| rx_frame_code | input | 3 | Page code of the received frame |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_head | output | 5 | Packet number at the head of the receive FIFO |
| tx_valid | output | 1 | Transmit queue holds a packet |
| tx_pkt | output | 5 | Packet number at the head of the transmit queue |
| tx_done | input | 1 | MAC has sent the head packet (ready) |

## Verification
The race that matters is a received frame claiming pages in the very cycle that a host allocation finishes its search. Both searches work from the same bitmap. The bench provokes this race by raising rx_frame exactly in the final busy cycle of an allocation, in both directed and random runs. A reference bitmap in the bench serves the frame first and then searches for the host, and the resulting alloc_pkt and rx_head are compared against it. A second overlap, a done-bit clear landing on the completion edge, is driven the same way and judged by irq_alloc staying set.

// File: rtl/pa_pkg.sv
package pa_pkg;
  typedef enum logic [1:0] {
    OP_ALLOC = 2'd0,
    OP_ENQ   = 2'd1,
    OP_REL   = 2'd2,
    OP_RST   = 2'd3
  } pa_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ALLOC = 2'd1,
    ST_REL   = 2'd2
  } pa_state_e;
endpackage

// File: rtl/pa_firstfit.sv
// Finds the lowest start page of a run of (code+1) free pages.
module pa_firstfit #(
  parameter int NUM_PAGES = 32,
  parameter int MAX_RUN   = 8,
  localparam int PN_W     = $clog2(NUM_PAGES),
  localparam int CODE_W   = $clog2(MAX_RUN)
) (
  input  logic [NUM_PAGES-1:0] free_map,
  input  logic [CODE_W-1:0]    code,
  output logic                 found,
  output logic [PN_W-1:0]      start
);
  always_comb begin
    found = 1'b0;
    start = '0;
    for (int s = NUM_PAGES - 1; s >= 0; s--) begin
      logic fit;
      fit = 1'b1;
      for (int k = 0; k < MAX_RUN; k++) begin
        if (k <= int'(code)) begin
          if (s + k >= NUM_PAGES) fit = 1'b0;
          else if (!free_map[(s + k) % NUM_PAGES]) fit = 1'b0;
        end
      end
      if (fit) begin
        found = 1'b1;
        start = PN_W'(s);
      end
    end
  end
endmodule

// File: rtl/pa_span.sv
// Expands a start page and a page code into a page mask.
module pa_span #(
  parameter int NUM_PAGES = 32,
  parameter int MAX_RUN   = 8,
  localparam int PN_W     = $clog2(NUM_PAGES),
  localparam int CODE_W   = $clog2(MAX_RUN)
) (
  input  logic                 en,
  input  logic [PN_W-1:0]      start,
  input  logic [CODE_W-1:0]    code,
  output logic [NUM_PAGES-1:0] mask
);
  for (genvar i = 0; i < NUM_PAGES; i++) begin : g_bit
    assign mask[i] = en && (i >= int'(start)) && (i <= int'(start) + int'(code));
  end
endmodule

// File: rtl/pa_fifo.sv
// Small synchronous FIFO of packet numbers with flush.
module pa_fifo #(
  parameter int W     = 5,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         one
);
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [AW:0]   count;
  logic          do_push, do_pop, full;

  assign empty   = (count == '0);
  assign one     = (count == (AW+1)'(1));
  assign full    = (count == (AW+1)'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (do_push && !flush) begin
      mem[wr_ptr] <= push_data;
    end
  end
endmodule

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc
  import pa_pkg::*;
#(
  parameter int NUM_PAGES = 32,
  parameter int MAX_RUN   = 8,
  parameter int ALLOC_LAT = 2,
  parameter int REL_LAT   = 4,
  localparam int PN_W     = $clog2(NUM_PAGES),
  localparam int CODE_W   = $clog2(MAX_RUN),
  localparam int REQ_W    = CODE_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [REQ_W-1:0] cmd_arg,
  input  logic [PN_W-1:0]  cmd_pkt,
  output logic             busy,
  output logic [PN_W-1:0]  alloc_pkt,
  output logic             alloc_fail,
  output logic             irq_alloc,
  input  logic             irq_alloc_clr,
  output logic             irq_txempty,
  input  logic             irq_txempty_clr,
  input  logic             rx_frame,
  input  logic [CODE_W-1:0] rx_frame_code,
  output logic             rx_empty,
  output logic [PN_W-1:0]  rx_head,
  output logic             tx_valid,
  output logic [PN_W-1:0]  tx_pkt,
  input  logic             tx_done
);
  localparam int LAT_MAX = (ALLOC_LAT > REL_LAT) ? ALLOC_LAT : REL_LAT;
  localparam int CNT_W   = $clog2(LAT_MAX + 1);

  pa_state_e            state;
  logic [CNT_W-1:0]     cnt;
  logic [REQ_W-1:0]     pend_code;
  logic [NUM_PAGES-1:0] free_map;
  logic [CODE_W-1:0]    size_tab [NUM_PAGES];

  logic accept, do_reset, do_enq, alloc_fin, rel_fin;
  logic too_big;
  logic rx_found, host_found, rx_ok, host_ok;
  logic [PN_W-1:0] rx_start, host_start;
  logic [NUM_PAGES-1:0] rx_mask, host_mask, rel_mask, tx_mask;
  logic rel_do, tx_pop, tx_empty, tx_one, rx_one;

  assign busy      = (state != ST_IDLE);
  assign accept    = cmd_valid && !busy;
  assign do_reset  = accept && (pa_op_e'(cmd_op) == OP_RST);
  assign do_enq    = accept && (pa_op_e'(cmd_op) == OP_ENQ);
  assign alloc_fin = (state == ST_ALLOC) && (cnt == '0);
  assign rel_fin   = (state == ST_REL) && (cnt == '0);
  assign too_big   = (int'(pend_code) >= MAX_RUN);

  // received frames search first
  pa_firstfit #(.NUM_PAGES(NUM_PAGES), .MAX_RUN(MAX_RUN)) u_rx_fit (
    .free_map (free_map),
    .code     (rx_frame_code),
    .found    (rx_found),
    .start    (rx_start)
  );
  assign rx_ok = rx_frame && rx_found && !do_reset;

  pa_span #(.NUM_PAGES(NUM_PAGES), .MAX_RUN(MAX_RUN)) u_rx_span (
    .en (rx_ok), .start (rx_start), .code (rx_frame_code), .mask (rx_mask)
  );

  // host search sees what the frame left
  pa_firstfit #(.NUM_PAGES(NUM_PAGES), .MAX_RUN(MAX_RUN)) u_host_fit (
    .free_map (free_map & ~rx_mask),
    .code     (pend_code[CODE_W-1:0]),
    .found    (host_found),
    .start    (host_start)
  );
  assign host_ok = alloc_fin && !too_big && host_found;

  pa_span #(.NUM_PAGES(NUM_PAGES), .MAX_RUN(MAX_RUN)) u_host_span (
    .en (host_ok), .start (host_start), .code (pend_code[CODE_W-1:0]), .mask (host_mask)
  );

  // freeing paths
  assign rel_do = rel_fin && !rx_empty;
  assign tx_pop = tx_done && !tx_empty;

  pa_span #(.NUM_PAGES(NUM_PAGES), .MAX_RUN(MAX_RUN)) u_rel_span (
    .en (rel_do), .start (rx_head), .code (size_tab[rx_head]), .mask (rel_mask)
  );
  pa_span #(.NUM_PAGES(NUM_PAGES), .MAX_RUN(MAX_RUN)) u_tx_span (
    .en (tx_pop), .start (tx_pkt), .code (size_tab[tx_pkt]), .mask (tx_mask)
  );

  pa_fifo #(.W(PN_W), .DEPTH(NUM_PAGES)) u_rx_q (
    .clk (clk), .rst_n (rst_n), .flush (do_reset),
    .push (rx_ok), .push_data (rx_start), .pop (rel_do),
    .head (rx_head), .empty (rx_empty), .one (rx_one)
  );

  pa_fifo #(.W(PN_W), .DEPTH(NUM_PAGES)) u_tx_q (
    .clk (clk), .rst_n (rst_n), .flush (do_reset),
    .push (do_enq), .push_data (cmd_pkt), .pop (tx_pop),
    .head (tx_pkt), .empty (tx_empty), .one (tx_one)
  );
  assign tx_valid = !tx_empty;

  // command sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      pend_code <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept && pa_op_e'(cmd_op) == OP_ALLOC) begin
            state     <= ST_ALLOC;
            cnt       <= CNT_W'(ALLOC_LAT - 1);
            pend_code <= cmd_arg;
          end else if (accept && pa_op_e'(cmd_op) == OP_REL) begin
            state <= ST_REL;
            cnt   <= CNT_W'(REL_LAT - 1);
          end
        end
        default: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
      endcase
    end
  end

  // page bitmap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        free_map <= '1;
    else if (do_reset) free_map <= '1;
    else               free_map <= (free_map | rel_mask | tx_mask) & ~rx_mask & ~host_mask;
  end

  // run length per start page
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PAGES; i++) size_tab[i] <= '0;
    end else begin
      if (rx_ok)   size_tab[rx_start]   <= rx_frame_code;
      if (host_ok) size_tab[host_start] <= pend_code[CODE_W-1:0];
    end
  end

  // result register and status bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alloc_pkt   <= '0;
      alloc_fail  <= 1'b0;
      irq_alloc   <= 1'b0;
      irq_txempty <= 1'b0;
    end else begin
      if (do_reset) begin
        alloc_fail <= 1'b0;
      end else if (alloc_fin) begin
        if (host_ok) begin
          alloc_pkt  <= host_start;
          alloc_fail <= 1'b0;
        end else begin
          alloc_fail <= 1'b1;
        end
      end
      if (alloc_fin)          irq_alloc <= 1'b1;
      else if (irq_alloc_clr) irq_alloc <= 1'b0;
      if (tx_pop && tx_one && !do_enq && !do_reset) irq_txempty <= 1'b1;
      else if (irq_txempty_clr)                     irq_txempty <= 1'b0;
    end
  end
endmodule

// File: rtl/pkt_page_alloc_chk.sv
module pkt_page_alloc_chk #(
  parameter int NUM_PAGES = 32,
  parameter int MAX_RUN   = 8,
  parameter int ALLOC_LAT = 2,
  parameter int REL_LAT   = 4,
  localparam int PN_W     = $clog2(NUM_PAGES),
  localparam int REQ_W    = $clog2(MAX_RUN) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic [REQ_W-1:0] cmd_arg,
  input logic             busy,
  input logic [PN_W-1:0]  alloc_pkt,
  input logic             alloc_fail,
  input logic             irq_alloc,
  input logic             irq_alloc_clr,
  input logic             irq_txempty,
  input logic             rx_empty,
  input logic             tx_valid,
  input logic             tx_done
);
  logic            op_run, op_rel, big_q;
  logic [PN_W-1:0] pkt_q;
  int              run_cnt;
  logic            acc_long;

  assign acc_long = cmd_valid && !busy && (cmd_op == 2'd0 || cmd_op == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_run  <= 1'b0;
      op_rel  <= 1'b0;
      big_q   <= 1'b0;
      pkt_q   <= '0;
      run_cnt <= 0;
    end else if (acc_long) begin
      op_run  <= 1'b1;
      op_rel  <= (cmd_op == 2'd2);
      big_q   <= (int'(cmd_arg) >= MAX_RUN);
      pkt_q   <= alloc_pkt;
      run_cnt <= 0;
    end else if (op_run) begin
      if (busy) run_cnt <= run_cnt + 1;
      else      op_run  <= 1'b0;
    end
  end

  AST_ALLOC_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == 2'd0) |=> busy); // R2
  AST_ALLOC_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_run && !busy && !op_rel) |-> (run_cnt == ALLOC_LAT && irq_alloc)); // R2
  AST_BIG_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_run && !busy && !op_rel && big_q) |-> (alloc_fail && alloc_pkt == pkt_q)); // R3
  AST_DONE_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_alloc && irq_alloc_clr && !busy) |=> !irq_alloc); // R5
  AST_TXEMPTY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_txempty) |-> !tx_valid); // R7
  AST_REL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_run && !busy && op_rel) |-> (run_cnt == REL_LAT)); // R9
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && cmd_op == 2'd1 && !tx_valid) |=> !tx_valid); // R10
  AST_RESET_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == 2'd3) |=> (!alloc_fail && rx_empty && !tx_valid && !busy)); // R11
endmodule

bind pkt_page_alloc pkt_page_alloc_chk #(
  .NUM_PAGES (NUM_PAGES),
  .MAX_RUN   (MAX_RUN),
  .ALLOC_LAT (ALLOC_LAT),
  .REL_LAT   (REL_LAT)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .cmd_op        (cmd_op),
  .cmd_arg       (cmd_arg),
  .busy          (busy),
  .alloc_pkt     (alloc_pkt),
  .alloc_fail    (alloc_fail),
  .irq_alloc     (irq_alloc),
  .irq_alloc_clr (irq_alloc_clr),
  .irq_txempty   (irq_txempty),
  .rx_empty      (rx_empty),
  .tx_valid      (tx_valid),
  .tx_done       (tx_done)
);

// File: tb/pkt_page_alloc_bench.sv
`timescale 1ns/1ps
module pkt_page_alloc_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [3:0] cmd_arg = '0;
  logic [4:0] cmd_pkt = '0;
  logic busy, alloc_fail, irq_alloc, irq_txempty, rx_empty, tx_valid;
  logic [4:0] alloc_pkt, rx_head, tx_pkt;
  logic irq_alloc_clr = 1'b0, irq_txempty_clr = 1'b0;
  logic rx_frame = 1'b0;
  logic [2:0] rx_frame_code = '0;
  logic tx_done = 1'b0;

  always #10 clk = ~clk;

  pkt_page_alloc u_pkt_page_alloc (
    .clk (clk), .rst_n (rst_n),
    .cmd_valid (cmd_valid), .cmd_op (cmd_op), .cmd_arg (cmd_arg), .cmd_pkt (cmd_pkt),
    .busy (busy), .alloc_pkt (alloc_pkt), .alloc_fail (alloc_fail),
    .irq_alloc (irq_alloc), .irq_alloc_clr (irq_alloc_clr),
    .irq_txempty (irq_txempty), .irq_txempty_clr (irq_txempty_clr),
    .rx_frame (rx_frame), .rx_frame_code (rx_frame_code),
    .rx_empty (rx_empty), .rx_head (rx_head),
    .tx_valid (tx_valid), .tx_pkt (tx_pkt), .tx_done (tx_done)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // reference state
  logic [31:0] mfree = '1;
  int msz [32];
  int rxq[$], txq[$], hl[$];
  int mpkt = 0;
  int mfail = 0, mirq = 0, mtx = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int first_fit(logic [31:0] fm, int n);
    for (int s = 0; s + n <= 32; s++) begin
      bit ok = 1;
      for (int k = 0; k < n; k++) if (!fm[s+k]) ok = 0;
      if (ok) return s;
    end
    return -1;
  endfunction

  function automatic void m_take(int s, int code);
    for (int k = 0; k <= code; k++) mfree[s+k] = 1'b0;
    msz[s] = code;
  endfunction

  function automatic void m_give(int s);
    for (int k = 0; k <= msz[s]; k++) mfree[s+k] = 1'b1;
  endfunction

  function automatic void m_rx(int code);
    int s = first_fit(mfree, code + 1);
    if (s >= 0) begin
      m_take(s, code);
      rxq.push_back(s);
    end
  endfunction

  function automatic void m_host(int code);
    int s;
    mirq = 1;
    if (code > 7) begin
      mfail = 1;
      return;
    end
    s = first_fit(mfree, code + 1);
    if (s < 0) mfail = 1;
    else begin
      m_take(s, code);
      mpkt = s; mfail = 0;
      hl.push_back(s);
    end
  endfunction

  task automatic compare_all(input string req);
    chk(req, "busy", int'(busy), 0);
    chk(req, "irq_alloc", int'(irq_alloc), mirq);
    chk(req, "alloc_fail", int'(alloc_fail), mfail);
    chk(req, "alloc_pkt", int'(alloc_pkt), mpkt);
    chk(req, "irq_txempty", int'(irq_txempty), mtx);
    chk(req, "rx_empty", int'(rx_empty), int'(rxq.size() == 0));
    if (rxq.size() > 0) chk(req, "rx_head", int'(rx_head), rxq[0]);
    chk(req, "tx_valid", int'(tx_valid), int'(txq.size() > 0));
    if (txq.size() > 0) chk(req, "tx_pkt", int'(tx_pkt), txq[0]);
  endtask

  task automatic t_alloc(int code, bit coll, int rcode, bit clr_done, string req);
    cmd_valid = 1; cmd_op = 2'd0; cmd_arg = 4'(code);
    cyc();
    cmd_valid = 0;
    cyc();
    chk(req, "busy during allocate", int'(busy), 1);
    if (coll) begin rx_frame = 1; rx_frame_code = 3'(rcode); end
    if (clr_done) irq_alloc_clr = 1;
    cyc();
    rx_frame = 0; irq_alloc_clr = 0;
    if (coll) m_rx(rcode);
    m_host(code);
    compare_all(req);
  endtask

  task automatic t_rx(int code, string req);
    rx_frame = 1; rx_frame_code = 3'(code);
    cyc();
    rx_frame = 0;
    m_rx(code);
    compare_all(req);
  endtask

  task automatic t_release(string req);
    cmd_valid = 1; cmd_op = 2'd2;
    cyc();
    cmd_valid = 0;
    cyc(); cyc(); cyc();
    chk(req, "busy in last release cycle", int'(busy), 1);
    cyc();
    if (rxq.size() > 0) begin
      m_give(rxq[0]);
      void'(rxq.pop_front());
    end
    compare_all(req);
  endtask

  task automatic t_enq(int p, string req);
    cmd_valid = 1; cmd_op = 2'd1; cmd_pkt = 5'(p);
    cyc();
    cmd_valid = 0;
    txq.push_back(p);
    compare_all(req);
  endtask

  task automatic t_txdone(string req);
    tx_done = 1;
    cyc();
    tx_done = 0;
    if (txq.size() > 0) begin
      m_give(txq[0]);
      void'(txq.pop_front());
      if (txq.size() == 0) mtx = 1;
    end
    compare_all(req);
  endtask

  task automatic t_reset_cmd(string req);
    cmd_valid = 1; cmd_op = 2'd3;
    cyc();
    cmd_valid = 0;
    mfree = '1; rxq.delete(); txq.delete(); hl.delete(); mfail = 0;
    compare_all(req);
  endtask

  task automatic t_clears(string req);
    irq_alloc_clr = 1; irq_txempty_clr = 1;
    cyc();
    irq_alloc_clr = 0; irq_txempty_clr = 0;
    mirq = 0; mtx = 0;
    compare_all(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare_all("R1");

    // first-fit packing
    t_alloc(0, 0, 0, 0, "R2");   // pkt 0
    t_alloc(2, 0, 0, 0, "R2");   // pkt 1, pages 1..3
    t_alloc(1, 0, 0, 0, "R2");   // pkt 4
    t_alloc(8, 0, 0, 0, "R3");   // too large
    t_alloc(1, 0, 0, 0, "R4");   // success clears fail
    t_clears("R5");
    t_alloc(0, 0, 0, 1, "R5");   // clear loses to completion

    // receive path
    t_rx(0, "R8");
    t_rx(2, "R8");

    // transmit path with auto release
    t_enq(1, "R6");
    t_enq(4, "R6");
    t_txdone("R7");
    t_txdone("R7");
    t_clears("R7");
    t_alloc(2, 0, 0, 0, "R7");   // reuses freed low pages

    // release
    t_release("R9");
    t_release("R9");
    t_release("R9");             // empty FIFO

    // frame and host allocation on the same edge
    t_alloc(0, 1, 0, 0, "R12");
    t_alloc(3, 1, 3, 0, "R12");

    // exhaust memory
    for (int i = 0; i < 6; i++) t_alloc(7, 0, 0, 0, "R4");
    t_rx(7, "R8");

    // command while busy is ignored
    cmd_valid = 1; cmd_op = 2'd0; cmd_arg = 4'd0;
    cyc();
    cmd_valid = 1; cmd_op = 2'd1; cmd_pkt = 5'd9;
    cyc();
    cmd_valid = 0;
    chk("R10", "busy", int'(busy), 1);
    cyc();
    m_host(0);
    compare_all("R10");

    t_reset_cmd("R11");
    t_alloc(7, 0, 0, 0, "R11");

    // random phase
    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom % 7);
      case (op)
        0, 1: t_alloc(int'($urandom % 10), ($urandom % 4) == 0, int'($urandom % 4), ($urandom % 5) == 0, "R12");
        2: t_rx(int'($urandom % 4), "R8");
        3: t_release("R9");
        4: if (hl.size() > 0) t_enq(hl.pop_front(), "R6");
        5: t_txdone("R7");
        default: begin
          if ($urandom % 8 == 0) t_reset_cmd("R11");
          else t_clears("R5");
        end
      endcase
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule